// File: doc/BRIEF.md
# Multiplexed-Bus Register File with Interrupt

This block is the host-side register bank of a line-interface controller. A microcontroller reaches it over a shared 8-bit address/data bus. During the address phase the host drives the register address on the low bus bits and asserts the chip select. The falling edge of the address-latch strobe captures both the address and the select. In the data phase, read and write strobes move bytes between the bus and the addressed register. The bus is driven through an output-enable pair, `ad_o` and `ad_oe`, so the pad ring can build the tri-state buffer.

The bank has eight byte-wide locations. Locations 0 to 3 are control registers and location 4 is the tone register. Location 5 is an auxiliary register whose bit 0 selects the clock-output source. These six locations can be read and written. Location 6 holds sticky detect flags, which internal event pulses set. Location 7 returns a fixed identification byte. An active-low interrupt stays asserted while any detect flag is set, and it is cleared by reading location 6. All strobes are sampled on the block clock, and their edges are found by comparing each strobe with its value one cycle earlier.

Top module: `mbus_regfile`

## Requirements
- R1: The address (`ad_i[2:0]`) and the active state of `cs_n` are latched at the first clock at which `ale` is seen low after having been high. Later bus activity does not change the target until the next fall of `ale`.
- R2: A write takes place at the first clock at which `wr_n` is seen high after being low. It stores `ad_i` into the latched location only if the latched chip select was active (low). When the latched select is inactive, nothing is written.
- R3: `ad_oe` is high only while `rd_n` is low and the latched chip select is active. While it is high, `ad_o` presents the addressed register.
- R4: Writes to location 6 (detect) and location 7 (ID) change no register. Location 7 always reads `ID_VALUE`.
- R5: A one-cycle high pulse on any bit of `det_evt` sets the matching bit of location 6. That bit stays set until location 6 is read.
- R6: `int_n` is low while any detect bit is set. A read of location 6 clears the flags at the clock where `rd_n` returns high, so `int_n` goes high unless a new event arrives in that same cycle.
- R7: While `rst` is high, all six read/write registers and the detect flags are cleared. As a result, `clk_sel` returns to 0, which selects the crystal frequency.
- R8: `dtmf_on` equals tone-register bit 4 AND control-register-0 bit 1. `tone_code` equals tone-register bits 3:0.
- R9: `clk_sel` follows bit 0 of location 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Active-high synchronous reset |
| ale | input | 1 | Address-latch strobe; its falling edge captures the address and the select |
| cs_n | input | 1 | Chip select, active low, captured with the address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data is taken on its rising edge |
| ad_i | input | 8 | Bus value seen at the pads |
| ad_o | output | 8 | Read data towards the pads |
| ad_oe | output | 1 | Pad output enable for `ad_o` |
| det_evt | input | 8 | One-cycle event pulses that set the detect flags |
| int_n | output | 1 | Interrupt, active low |
| ctrl_regs | output | 32 | Control registers 0 to 3, with register 0 in the low byte |
| tone_code | output | 4 | Selected tone pair |
| dtmf_on | output | 1 | Tone transmission enabled (tone select gated by transmit enable) |
| clk_sel | output | 1 | Clock-output source, where 0 selects the crystal |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 3-bit address and an identification byte of 8'h5C. With these values every one of the eight locations can be addressed, and full-byte random patterns reach each bit of the read/write registers and each detect flag. Random cycles mix writes with an active or inactive select, reads of all locations, reads with the select inactive, and event pulses. A reference model in the bench tracks the register contents. Directed cases cover three corners. In the first, the data byte's low bits name a different location than the latched address. In the second, writes target the read-only locations. In the third, reset is applied in mid-run.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int BUS_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int RW_REGS    = 6;
    localparam int CTRL_REGS  = 4;
    localparam int LOC_TONE   = 4;
    localparam int LOC_AUX    = 5;
    localparam int LOC_DET    = 6;
    localparam int LOC_ID     = 7;
    localparam int TONE_SEL_B = 4;
    localparam int CR0_TXEN_B = 1;
    localparam int TONE_CODE_W = 4;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic              sel;
        logic [ADDR_W-1:0] addr;
    } front_state_t;
endpackage

// File: rtl/mbus_front.sv
module mbus_front
    import mbus_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] ad_i,
    output logic [AW-1:0] addr_q,
    output logic          sel_q,
    output logic          wr_fire,
    output logic          rd_end,
    output logic          rd_active
);
    typedef struct packed {
        logic          ale;
        logic          rd_n;
        logic          wr_n;
        logic          sel;
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ale  = ale;
        st_d.rd_n = rd_n;
        st_d.wr_n = wr_n;
        if (st_q.ale && !ale) begin
            st_d.addr = ad_i[AW-1:0];
            st_d.sel  = !cs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1, sel: 1'b0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q    = st_q.addr;
    assign sel_q     = st_q.sel;
    assign wr_fire   = !st_q.wr_n && wr_n && st_q.sel;
    assign rd_end    = !st_q.rd_n && rd_n && st_q.sel;
    assign rd_active = !rd_n && st_q.sel;

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !($past(ale) && !ale) |=> $stable(st_q.addr) && $stable(st_q.sel));
endmodule

// File: rtl/mbus_rwbank.sv
module mbus_rwbank
    import mbus_pkg::*;
#(
    parameter int DW  = BUS_W,
    parameter int AW  = ADDR_W,
    parameter int NRW = RW_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [NRW*DW-1:0] regs_q
);
    logic [NRW*DW-1:0] regs_d;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NRW; i++) begin
            if (wr_fire && (int'(addr) == i)) begin
                regs_d[i*DW +: DW] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && int'(addr) >= NRW) |=> $stable(regs_q));

    for (genvar g = 0; g < NRW; g++) begin : g_wchk
        // R2
        wr_store_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_fire && int'(addr) == g) |=> regs_q[g*DW +: DW] == $past(wdata));
    end
endmodule

// File: rtl/mbus_detect.sv
module mbus_detect
    import mbus_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt,
    input  logic          clr,
    output logic [DW-1:0] flags_q,
    output logic          irq_n
);
    logic [DW-1:0] flags_d;

    always_comb begin
        if (clr) begin
            flags_d = evt;
        end else begin
            flags_d = flags_q | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign irq_n = ~(|flags_q);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R5
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> !irq_n);

    // R6
    clr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> irq_n);
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int          DW       = BUS_W,
    parameter int          AW       = ADDR_W,
    parameter logic [7:0]  ID_VALUE = 8'h5C
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ale,
    input  logic                      cs_n,
    input  logic                      rd_n,
    input  logic                      wr_n,
    input  logic [DW-1:0]             ad_i,
    output logic [DW-1:0]             ad_o,
    output logic                      ad_oe,
    input  logic [DW-1:0]             det_evt,
    output logic                      int_n,
    output logic [CTRL_REGS*DW-1:0]   ctrl_regs,
    output logic [TONE_CODE_W-1:0]    tone_code,
    output logic                      dtmf_on,
    output logic                      clk_sel
);
    localparam int NRW = RW_REGS;

    logic [AW-1:0]     addr_q;
    logic              sel_q;
    logic              wr_fire;
    logic              rd_end;
    logic              rd_active;
    logic [NRW*DW-1:0] rw_q;
    logic [DW-1:0]     det_q;
    logic              det_clr;
    logic [DW-1:0]     tone_q;
    logic [DW-1:0]     aux_q;

    mbus_front #(.DW(DW), .AW(AW)) u_front (
        .clk       (clk),
        .rst       (rst),
        .ale       (ale),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_i      (ad_i),
        .addr_q    (addr_q),
        .sel_q     (sel_q),
        .wr_fire   (wr_fire),
        .rd_end    (rd_end),
        .rd_active (rd_active)
    );

    mbus_rwbank #(.DW(DW), .AW(AW), .NRW(NRW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (wr_fire),
        .addr    (addr_q),
        .wdata   (ad_i),
        .regs_q  (rw_q)
    );

    assign det_clr = rd_end && (int'(addr_q) == LOC_DET);

    mbus_detect #(.DW(DW)) u_det (
        .clk     (clk),
        .rst     (rst),
        .evt     (det_evt),
        .clr     (det_clr),
        .flags_q (det_q),
        .irq_n   (int_n)
    );

    always_comb begin
        ad_o = '0;
        if (int'(addr_q) < NRW) begin
            ad_o = rw_q[int'(addr_q)*DW +: DW];
        end else if (int'(addr_q) == LOC_DET) begin
            ad_o = det_q;
        end else begin
            ad_o = DW'(ID_VALUE);
        end
    end

    assign ad_oe     = rd_active;
    assign tone_q    = rw_q[LOC_TONE*DW +: DW];
    assign aux_q     = rw_q[LOC_AUX*DW +: DW];
    assign ctrl_regs = rw_q[CTRL_REGS*DW-1:0];
    assign tone_code = tone_q[TONE_CODE_W-1:0];
    assign dtmf_on   = tone_q[TONE_SEL_B] & rw_q[CR0_TXEN_B];
    assign clk_sel   = aux_q[0];

    // R3
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_n || cs_n && !sel_q) |-> !ad_oe);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!clk_sel && !dtmf_on && int_n && ctrl_regs == '0));
endmodule

// File: tb/tb_mbus_regfile.sv
module tb_mbus_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] ad_i = 8'h00;
    logic [7:0] ad_o;
    logic       ad_oe;
    logic [7:0] det_evt = 8'h00;
    logic       int_n;
    logic [31:0] ctrl_regs;
    logic [3:0] tone_code;
    logic       dtmf_on;
    logic       clk_sel;

    localparam logic [7:0] ID_V = 8'h5C;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] m_rw [0:5];
    logic [7:0] m_det;

    always #4 clk = ~clk;

    mbus_regfile #(.ID_VALUE(ID_V)) dut (
        .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .det_evt(det_evt), .int_n(int_n),
        .ctrl_regs(ctrl_regs), .tone_code(tone_code), .dtmf_on(dtmf_on), .clk_sel(clk_sel)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        if (a < 3'd6) return m_rw[a];
        if (a == 3'd6) return m_det;
        return ID_V;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) m_rw[i] = 8'h00;
        m_det = 8'h00;
    endtask

    task automatic addr_phase(input logic [2:0] a, input logic sel);
        @(negedge clk);
        ad_i = {5'b10101, a};
        ale = 1'b1;
        cs_n = !sel;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic sel);
        addr_phase(a, sel);
        ad_i = d;
        wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (sel && a < 3'd6) m_rw[a] = d;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic sel, output logic [7:0] d, output logic oe);
        addr_phase(a, sel);
        ad_i = 8'hFF;
        rd_n = 1'b0;
        @(negedge clk);
        d = ad_o;
        oe = ad_oe;
        rd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (sel && a == 3'd6) m_det = 8'h00;
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        @(negedge clk);
        det_evt = e;
        @(negedge clk);
        det_evt = 8'h00;
        m_det = m_det | e;
    endtask

    task automatic read_chk(input logic [2:0] a, input string req);
        logic [7:0] d, e;
        logic oe;
        e = exp_read(a);
        bus_read(a, 1'b1, d, oe);
        chk(oe === 1'b1, req, {31'd0, oe}, 32'd1);
        chk(d === e, req, {24'd0, d}, {24'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        void'($urandom(32'd1234));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7 reset state
        chk(int_n === 1'b1 && clk_sel === 1'b0 && dtmf_on === 1'b0 && ctrl_regs === 32'd0,
            "R7 reset outputs", {int_n, clk_sel, dtmf_on, ctrl_regs[28:0]}, 32'h8000_0000);
        chk(ad_oe === 1'b0, "R3 idle bus", {31'd0, ad_oe}, 32'd0);
        for (int a = 0; a < 8; a++) read_chk(3'(a), "R7 reset read");

        // R1 data low bits name another location than the latched one
        bus_write(3'd2, 8'h05, 1'b1);
        read_chk(3'd2, "R1 latched target");
        read_chk(3'd5, "R1 other location untouched");

        // R2 inactive select ignores write
        bus_write(3'd3, 8'hE7, 1'b0);
        read_chk(3'd3, "R2 inactive select");

        // R3 read with inactive select leaves bus undriven
        bus_read(3'd7, 1'b0, d, oe);
        chk(oe === 1'b0, "R3 inactive select read", {31'd0, oe}, 32'd0);

        // R4 read-only locations
        bus_write(3'd7, 8'h11, 1'b1);
        bus_write(3'd6, 8'hFF, 1'b1);
        chk(int_n === 1'b1, "R4 detect write ignored", {31'd0, int_n}, 32'd1);
        read_chk(3'd7, "R4 id");
        read_chk(3'd6, "R4 detect");
        for (int a = 0; a < 6; a++) read_chk(3'(a), "R4 rw unchanged");

        // R5 R6 sticky flags and interrupt
        pulse_evt(8'h24);
        @(negedge clk);
        chk(int_n === 1'b0, "R6 int set", {31'd0, int_n}, 32'd0);
        pulse_evt(8'h01);
        read_chk(3'd6, "R5 sticky accumulate");
        chk(int_n === 1'b1, "R6 int cleared by read", {31'd0, int_n}, 32'd1);
        read_chk(3'd6, "R5 cleared after read");

        // R8 R9 decoded outputs
        bus_write(3'd4, 8'h1A, 1'b1);
        chk(dtmf_on === 1'b0, "R8 gated off", {31'd0, dtmf_on}, 32'd0);
        bus_write(3'd0, 8'h02, 1'b1);
        chk(dtmf_on === 1'b1 && tone_code === 4'hA, "R8 gated on", {27'd0, dtmf_on, tone_code}, 32'h1A);
        bus_write(3'd5, 8'h01, 1'b1);
        chk(clk_sel === 1'b1, "R9 clock select", {31'd0, clk_sel}, 32'd1);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [2:0] a;
            logic [7:0] v;
            op = int'($urandom_range(0, 9));
            a = 3'($urandom_range(0, 7));
            v = 8'($urandom);
            if (op < 4) begin
                bus_write(a, v, ($urandom_range(0, 4) != 0));
            end else if (op < 7) begin
                read_chk(a, "R2 R3 R5 random read");
            end else if (op < 8) begin
                bus_read(a, 1'b0, d, oe);
                chk(oe === 1'b0, "R3 random inactive read", {31'd0, oe}, 32'd0);
            end else begin
                pulse_evt(v);
                @(negedge clk);
                chk(int_n === (m_det == 8'h00), "R6 random int", {31'd0, int_n}, {31'd0, m_det == 8'h00});
            end
            chk(dtmf_on === (m_rw[4][4] & m_rw[0][1]) && tone_code === m_rw[4][3:0],
                "R8 random", {27'd0, dtmf_on, tone_code}, {27'd0, m_rw[4][4] & m_rw[0][1], m_rw[4][3:0]});
            chk(clk_sel === m_rw[5][0] && ctrl_regs === {m_rw[3], m_rw[2], m_rw[1], m_rw[0]},
                "R9 random", {31'd0, clk_sel}, {31'd0, m_rw[5][0]});
        end

        // R7 mid-run reset
        bus_write(3'd5, 8'h01, 1'b1);
        pulse_evt(8'h80);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk(clk_sel === 1'b0 && int_n === 1'b1, "R7 mid-run reset", {30'd0, clk_sel, int_n}, 32'd1);
        for (int a = 0; a < 8; a++) read_chk(3'(a), "R7 after reset read");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule